// File: doc/BRIEF.md
# Calibration Constants Save/Restore Sequencer

This block runs on the host side of a converter. It copies the converter's internal calibration constants into a local memory. Later it writes them back, so that a full calibration can be skipped. Every access goes through an abstract register port with a request/acknowledge handshake. A save is started by a one-cycle `save_req` pulse and a restore by a one-cycle `restore_req` pulse. The block then issues a fixed, ordered list of register operations and reports progress with `busy`, `done` and `err`.

Both kinds of transfer use the same bracket. First the block reads the control register to capture its current value. It then sets the snapshot-enable bit and powers both channels down. After the transfer it writes back the captured power bits and finally clears the snapshot-enable bit.

A save reads the constants register one more time than there are stored words, and the first word returned is discarded. A restore writes two more words than are stored, appending two dummy words. Restored constants are only meaningful if the converter runs under the same conditions as when they were saved. Keeping to that rule is left to the host.

Top module: `calsnap_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `reg_req` are all low.
- R2: Every transfer begins with a read of the control register (address `CTRL_ADDR`, default 4), which captures its value V. The next two operations are writes to that register: V with the snapshot bit `SNAP_BIT` (default 7) set, then V with bit 7 and both power-down bits `PDA_BIT`/`PDB_BIT` (default 10 and 11) set.
- R3: A save issues exactly `NWORDS+1` (default 184) reads of the constants register (address `CAL_ADDR`, default 5). The first word returned is discarded, and returned words 2 onward are stored at memory addresses 0 to `NWORDS-1`.
- R4: A restore issues exactly `NWORDS+2` (default 185) writes to the constants register. The stored words go out in memory order, followed by two writes of `DUMMY` (default 0).
- R5: After the transfer, the control register is written with V with bit 7 set, which restores the original power bits. The last operation writes V with bit 7 cleared.
- R6: Only one operation is outstanding at a time. Its address, direction and write data stay stable while `reg_req` is high without `reg_ack`.
- R7: `busy` is high from the cycle after the request until the acknowledge of the final control write. In the following cycle `busy` is low and `done` pulses high for one cycle.
- R8: A restore request when no save has completed since reset gives a one-cycle `err` pulse and issues no register operation. Starting a save clears the valid state, and completing it sets the valid state.
- R9: Requests that arrive while `busy` is high are ignored. If `save_req` and `restore_req` arrive in the same idle cycle, the save is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_req | input | 1 | Start a save (one-cycle pulse) |
| restore_req | input | 1 | Start a restore (one-cycle pulse) |
| reg_req | output | 1 | Register operation pending |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | AW | Register address |
| reg_wdata | output | DW | Write data |
| reg_ack | input | 1 | Operation complete (one-cycle pulse) |
| reg_rdata | input | DW | Read data, valid with `reg_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (one-cycle pulse) |
| err | output | 1 | Restore refused (one-cycle pulse) |

## Verification
The assertions assume that the register port raises `reg_ack` only while `reg_req` is high, for a single cycle per operation, with `reg_rdata` valid in that same cycle. The bench responder models the converter's register file. It acknowledges only a pending request, after a programmable latency of zero to two idle cycles, and always drops `reg_ack` in the cycle after it raised it. The stimulus sweeps every combination of the two original power-down bits, changes the constants pattern from round to round, and injects requests while a transfer is in progress.

// File: rtl/calsnap_seq.sv
module calsnap_seq #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int NWORDS = 183,
  parameter int CTRL_ADDR = 4,
  parameter int CAL_ADDR = 5,
  parameter int SNAP_BIT = 7,
  parameter int PDA_BIT = 10,
  parameter int PDB_BIT = 11,
  parameter logic [DW-1:0] DUMMY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save_req,
  input  logic          restore_req,
  output logic          reg_req,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic          reg_ack,
  input  logic [DW-1:0] reg_rdata,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int CW = $clog2(NWORDS + 2);
  localparam logic [CW-1:0] RD_LAST = CW'(NWORDS);
  localparam logic [CW-1:0] WR_LAST = CW'(NWORDS + 1);
  localparam logic [DW-1:0] SNAP = DW'(1) << SNAP_BIT;
  localparam logic [DW-1:0] PDM = (DW'(1) << PDA_BIT) | (DW'(1) << PDB_BIT);

  typedef enum logic [2:0] {S_IDLE, S_RDC, S_SNAP, S_PD, S_XFER, S_PU, S_CLR} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] orig;
  logic is_save, valid;
  logic [DW-1:0] mem [NWORDS];

  logic [CW-1:0] last, widx;
  logic [DW-1:0] rd_word;

  assign last    = is_save ? RD_LAST : WR_LAST;
  assign widx    = cnt - 1'b1;
  assign rd_word = (cnt < CW'(NWORDS)) ? mem[cnt] : DUMMY;

  assign busy     = (st != S_IDLE);
  assign reg_req  = busy;
  assign reg_we   = (st != S_RDC) && !(st == S_XFER && is_save);
  assign reg_addr = (st == S_XFER) ? AW'(CAL_ADDR) : AW'(CTRL_ADDR);

  always_comb begin
    case (st)
      S_SNAP, S_PU: reg_wdata = orig | SNAP;
      S_PD:         reg_wdata = orig | SNAP | PDM;
      S_CLR:        reg_wdata = orig & ~SNAP;
      S_XFER:       reg_wdata = is_save ? '0 : rd_word;
      default:      reg_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      orig    <= '0;
      is_save <= 1'b0;
      valid   <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE:
          if (save_req) begin
            is_save <= 1'b1;
            valid   <= 1'b0;
            st      <= S_RDC;
          end else if (restore_req) begin
            if (valid) begin
              is_save <= 1'b0;
              st      <= S_RDC;
            end else begin
              err <= 1'b1;
            end
          end
        S_RDC:
          if (reg_ack) begin
            orig <= reg_rdata;
            st   <= S_SNAP;
          end
        S_SNAP: if (reg_ack) st <= S_PD;
        S_PD:
          if (reg_ack) begin
            cnt <= '0;
            st  <= S_XFER;
          end
        S_XFER:
          if (reg_ack) begin
            cnt <= cnt + 1'b1;
            if (cnt == last) st <= S_PU;
          end
        S_PU: if (reg_ack) st <= S_CLR;
        S_CLR:
          if (reg_ack) begin
            st   <= S_IDLE;
            done <= 1'b1;
            if (is_save) valid <= 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_XFER && is_save && reg_ack && cnt != '0)
      mem[widx] <= reg_rdata;
  end
endmodule

module calsnap_chk #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int CTRL_ADDR = 4,
  parameter int SNAP_BIT = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_req,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          reg_ack,
  input logic          busy,
  input logic          done,
  input logic          err
);
  AST_HOLD_OP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R7
  AST_CLR_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_ack && reg_we && reg_addr == AW'(CTRL_ADDR) && !reg_wdata[SNAP_BIT] |=> done && !reg_req); // R5
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !$past(reg_req)); // R8
  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !reg_req); // R8
  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R7
endmodule

bind calsnap_seq calsnap_chk #(.DW(DW), .AW(AW), .CTRL_ADDR(CTRL_ADDR), .SNAP_BIT(SNAP_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_ack(reg_ack), .busy(busy), .done(done), .err(err));

// File: tb/sim_calsnap_seq.sv
module sim_calsnap_seq;
  localparam int DW = 16, AW = 4, N = 183;
  localparam logic [DW-1:0] SNAP = 16'h0080, PDM = 16'h0C00;

  logic clk = 1'b0, rst_n = 1'b0, save_req = 1'b0, restore_req = 1'b0;
  logic reg_req, reg_we, reg_ack = 1'b0, busy, done, err;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata = '0;

  calsnap_seq u0 (.clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata), .busy(busy), .done(done), .err(err));

  always #10 clk = ~clk;

  int total = 0, bad = 0, finished = 0;
  int lat = 0, lat_cnt = 0, round = 0;
  logic [DW-1:0] ctrl;
  int nops, ncal_rd, ncal_wr, nctrl_wr, first_is_ctrl_rd, last_ctrl_seen;
  logic [DW-1:0] cw [4];
  logic [DW-1:0] wlog [N+2];

  function automatic logic [DW-1:0] calval(int r, int k);
    return DW'(16'h1000 * r + 3 * k + 7);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    nops = 0; ncal_rd = 0; ncal_wr = 0; nctrl_wr = 0; first_is_ctrl_rd = 0; last_ctrl_seen = 0;
  endtask

  // converter register file model
  initial begin
    forever begin
      @(negedge clk);
      if (reg_ack) begin
        reg_ack = 1'b0;
        if (last_ctrl_seen == 1) begin
          last_ctrl_seen = 2;
          chk(!busy && done, "R7 busy/done after final ack", {busy, done}, 1);
        end
      end else if (reg_req && rst_n) begin
        if (lat_cnt > 0) lat_cnt--;
        else begin
          lat_cnt = lat;
          if (nops == 0) first_is_ctrl_rd = (!reg_we && reg_addr == 4'd4) ? 1 : 0;
          nops++;
          if (reg_addr == 4'd4) begin
            if (reg_we) begin
              if (nctrl_wr < 4) cw[nctrl_wr] = reg_wdata;
              nctrl_wr++;
              ctrl = reg_wdata;
              if (!reg_wdata[7]) last_ctrl_seen = 1;
            end else reg_rdata = ctrl;
          end else if (reg_addr == 4'd5) begin
            if (reg_we) begin
              if (ncal_wr < N + 2) wlog[ncal_wr] = reg_wdata;
              ncal_wr++;
            end else begin
              reg_rdata = calval(round, ncal_rd);
              ncal_rd++;
            end
          end
          reg_ack = 1'b1;
        end
      end
    end
  end

  task automatic wait_end();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done || err) break;
    end
  endtask

  task automatic pulse(input bit s, input bit r);
    @(negedge clk);
    save_req = s; restore_req = r;
    @(negedge clk);
    save_req = 1'b0; restore_req = 1'b0;
  endtask

  task automatic check_bracket(input logic [DW-1:0] v);
    chk(first_is_ctrl_rd == 1, "R2 first op is control read", first_is_ctrl_rd, 1);
    chk(cw[0] == (v | SNAP), "R2 snapshot set", cw[0], v | SNAP);
    chk(cw[1] == (v | SNAP | PDM), "R2 power down", cw[1], v | SNAP | PDM);
    chk(cw[2] == (v | SNAP), "R5 power restore", cw[2], v | SNAP);
    chk(cw[3] == (v & ~SNAP), "R5 snapshot clear", cw[3], v & ~SNAP);
    chk(nctrl_wr == 4, "R5 control write count", nctrl_wr, 4);
    chk(last_ctrl_seen == 2, "R7 final ack observed", last_ctrl_seen, 2);
  endtask

  initial begin
    ctrl = 16'h0031;
    clear_log();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !reg_req, "R1 reset outputs", {busy, done, err, reg_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !reg_req, "R1 idle after reset", {busy, reg_req}, 0);

    // restore with no save
    pulse(1'b0, 1'b1);
    chk(err && !busy, "R8 err pulse without save", {err, busy}, 2);
    @(negedge clk);
    chk(!err && !busy && nops == 0, "R8 no ops issued", nops, 0);

    for (int p = 0; p < 4; p++) begin
      logic [DW-1:0] v;
      round = p + 1;
      lat = p % 3;
      v = 16'h0031 | DW'(p << 10) | DW'(p << 4);
      ctrl = v;
      clear_log();
      if (p == 2) pulse(1'b1, 1'b1);   // R9 both at once -> save
      else pulse(1'b1, 1'b0);
      chk(busy, "R7 busy after save request", busy, 1);
      repeat (50) @(negedge clk);
      restore_req = 1'b1; save_req = 1'b1;   // R9 ignored while busy
      @(negedge clk);
      restore_req = 1'b0; save_req = 1'b0;
      wait_end();
      chk(ncal_rd == N + 1, "R3 read count", ncal_rd, N + 1);
      chk(ncal_wr == 0, "R9 save chosen, no cal writes", ncal_wr, 0);
      chk(nops == N + 6, "R6 save op count", nops, N + 6);
      check_bracket(v);
      chk(ctrl == (v & ~SNAP), "R5 final control", ctrl, v & ~SNAP);
      repeat (3) @(negedge clk);
      chk(!busy && !reg_req, "R9 no second run", {busy, reg_req}, 0);

      ctrl = v;
      clear_log();
      pulse(1'b0, 1'b1);
      chk(busy && !err, "R8 restore accepted after save", {busy, err}, 2);
      wait_end();
      chk(ncal_wr == N + 2, "R4 write count", ncal_wr, N + 2);
      chk(ncal_rd == 0, "R4 no cal reads", ncal_rd, 0);
      chk(nops == N + 7, "R6 restore op count", nops, N + 7);
      for (int j = 0; j < N; j++)
        if (wlog[j] != calval(round, j + 1))
          chk(0, "R3 R4 restored word", wlog[j], calval(round, j + 1));
      total++;
      chk(wlog[N] == 16'h0 && wlog[N + 1] == 16'h0, "R4 dummy words", {wlog[N], wlog[N + 1]}, 0);
      check_bracket(v);
      repeat (3) @(negedge clk);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (finished == 0) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule